// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This block lets a host reach a 32-bit internal register bus through a window of three 64-bit memory-mapped registers. The host packs a command, an internal register address and write data into one control word. The bridge then runs exactly one request/acknowledge transaction on the internal bus. The host polls a status word until its completion flag is set, and for a read it takes the returned data from the same word.

A read-only parameter word sits next to the control and status words. It describes the serial master that is attached to the internal bus. Its contents come from constant configuration inputs. Internal registers are 32 bits wide and are addressed in steps of four bytes. The bridge passes the address through unchanged. A transaction finishes within a few cycles of the acknowledge, so the host usually sees completion on its first or second poll.

Top module: `regwin_bridge`

## Requirements
- R1: The host window is decoded on byte-address bits above bit 2. The parameter word is at offset 0x8, the control word at 0x10 and the status word at 0x18. A host read returns its data one cycle later, with `host_rvalid` high for that cycle. Offset 0x0 reads as zero. The control word reads back the last value written to it.
- R2: In the control word, bits 31:0 hold the write data, bits 44:32 hold the 13-bit internal address and bits 63:62 hold the command. The address and the write data appear on `ib_addr` and `ib_wdata` unchanged.
- R3: Command value 1 starts a read, which raises `ib_rd`. Command value 2 starts a write, which raises `ib_wr`. Values 0 and 3 start no transaction and leave the status word unchanged.
- R4: In the status word, bits 31:0 hold the read data and bit 32 holds the completion flag. Bits 63:33 read as zero.
- R5: Launching a read or write clears the completion flag. The flag sets on the clock edge where the acknowledge is seen. It then stays set through status reads and through writes to the other offsets, until the next launch.
- R6: For a read, `ib_rdata` is captured into the status read-data field on the same edge that sets the flag.
- R7: A write transaction leaves the status read-data field at its previous value.
- R8: A command written while a transaction is in flight is ignored: it reaches no bus, and the in-flight transaction completes unchanged.
- R9: A strobe stays high until `ib_ack`, with the address and data held stable. It drops on the edge where the acknowledge is seen. `ib_rd` and `ib_wr` are never high together.
- R10: The parameter word holds the shift order in bit 1 (1 means LSB first), the word width in bits 7:2, the chip-select count in bits 13:8, clock polarity in bit 14, clock phase in bit 15 and a peripheral ID in bits 47:32. All other bits are zero.
- R11: After reset the strobes are low, the status word is zero and `host_rvalid` is low.
- R12: The strobe rises in the cycle after the control write. Take a slave that acknowledges L cycles after it first sees a strobe, and a host that polls every second cycle starting one cycle after the write. That host sees the flag on poll number (L+4)/2, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Registered host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| cfg_lsb_first | input | 1 | Serial master shifts LSB first |
| cfg_word_bits | input | 6 | Serial master word width |
| cfg_cs_count | input | 6 | Number of chip selects |
| cfg_cpol | input | 1 | Clock polarity |
| cfg_cpha | input | 1 | Clock phase |
| cfg_periph_id | input | 16 | Peripheral identifier |
| ib_rd | output | 1 | Internal bus read request |
| ib_wr | output | 1 | Internal bus write request |
| ib_addr | output | 13 | Internal bus register address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal bus read data |

## Verification
The bench builds the bridge with its default parameters: a 5-bit host address, a 13-bit internal address and 32-bit data. It attaches a model slave with eight words whose acknowledge delay the bench sweeps from zero to three cycles. Every address and every delay gets a write and then a read-back. This makes the exact poll count of R12, the held-data rule on writes and the capture on reads checkable at each latency. The longest delay leaves enough in-flight cycles to test that a command is cleared and then ignored while busy.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;
  // host window: 64-bit words, index = byte address >> 3
  localparam int WORD_BYTES_LG = 3;
  localparam int HOST_DW       = 64;
  localparam int IX_PARAM      = 1;
  localparam int IX_CTRL       = 2;
  localparam int IX_STAT       = 3;

  // control word fields
  localparam int CW_DATA_LSB = 0;
  localparam int CW_DATA_W   = 32;
  localparam int CW_ADDR_LSB = 32;
  localparam int CW_ADDR_W   = 13;
  localparam int CW_CMD_LSB  = 62;
  localparam int CW_CMD_W    = 2;

  // status word fields
  localparam int SW_DATA_LSB  = 0;
  localparam int SW_VALID_BIT = 32;

  // parameter word fields
  localparam int PW_ORDER_BIT = 1;
  localparam int PW_WIDTH_LSB = 2;
  localparam int PW_WIDTH_W   = 6;
  localparam int PW_CS_LSB    = 8;
  localparam int PW_CS_W      = 6;
  localparam int PW_CPOL_BIT  = 14;
  localparam int PW_CPHA_BIT  = 15;
  localparam int PW_ID_LSB    = 32;
  localparam int PW_ID_W      = 16;

  typedef enum logic [CW_CMD_W-1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic                 is_rd;
    logic [CW_ADDR_W-1:0] addr;
    logic [CW_DATA_W-1:0] data;
  } req_t;
endpackage

// File: rtl/regwin_host_if.sv
`timescale 1ns/1ps
module regwin_host_if
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic [HOST_DW-1:0] param_word,
  input  logic [HOST_DW-1:0] status_word,
  output logic               ctrl_wr,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               host_rvalid
);
  localparam int IX_W = HOST_AW - WORD_BYTES_LG;
  localparam logic [IX_W-1:0] IXP = IX_W'(IX_PARAM);
  localparam logic [IX_W-1:0] IXC = IX_W'(IX_CTRL);
  localparam logic [IX_W-1:0] IXS = IX_W'(IX_STAT);

  logic [IX_W-1:0]    wix;
  logic [HOST_DW-1:0] ctrl_q;
  logic [HOST_DW-1:0] rd_mux;
  logic               unused_lo_bits;

  assign wix            = host_addr[HOST_AW-1:WORD_BYTES_LG];
  assign unused_lo_bits = ^host_addr[WORD_BYTES_LG-1:0];
  assign ctrl_wr        = host_wr_en && (wix == IXC);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= host_wdata;
  end

  always_comb begin
    case (wix)
      IXP:     rd_mux = param_word;
      IXC:     rd_mux = ctrl_q;
      IXS:     rd_mux = status_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd_en;
      if (host_rd_en) host_rdata <= rd_mux;
    end
  end

  // R1: every read is answered on the next cycle
  p_rd_resp_r1: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |=> host_rvalid);
  // R1: an unused offset never returns data
  p_hole_zero_r1: assert property (@(posedge clk) disable iff (rst)
    host_rd_en && (wix == '0) |=> host_rdata == '0);
endmodule

// File: rtl/regwin_cmd_decode.sv
`timescale 1ns/1ps
module regwin_cmd_decode
  import regwin_pkg::*;
(
  input  logic               ctrl_wr,
  input  logic [HOST_DW-1:0] ctrl_word,
  input  logic               busy,
  output logic               launch,
  output req_t               req
);
  cmd_e cmd;
  logic is_cmd;
  logic unused_gap_bits;

  assign cmd             = cmd_e'(ctrl_word[CW_CMD_LSB +: CW_CMD_W]);
  assign unused_gap_bits = ^ctrl_word[CW_CMD_LSB-1:CW_ADDR_LSB+CW_ADDR_W];
  assign is_cmd          = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign launch          = ctrl_wr && is_cmd && !busy;

  always_comb begin
    req.is_rd = (cmd == CMD_READ);
    req.addr  = ctrl_word[CW_ADDR_LSB +: CW_ADDR_W];
    req.data  = ctrl_word[CW_DATA_LSB +: CW_DATA_W];
  end
endmodule

// File: rtl/regwin_seq.sv
`timescale 1ns/1ps
module regwin_seq
  import regwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch,
  input  req_t                 req,
  input  logic                 ib_ack,
  output logic                 ib_rd,
  output logic                 ib_wr,
  output logic [CW_ADDR_W-1:0] ib_addr,
  output logic [CW_DATA_W-1:0] ib_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 done_is_rd
);
  assign busy       = ib_rd | ib_wr;
  assign done       = busy & ib_ack;
  assign done_is_rd = ib_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_rd    <= 1'b0;
      ib_wr    <= 1'b0;
      ib_addr  <= '0;
      ib_wdata <= '0;
    end else if (launch) begin
      ib_rd    <= req.is_rd;
      ib_wr    <= !req.is_rd;
      ib_addr  <= req.addr;
      ib_wdata <= req.data;
    end else if (done) begin
      ib_rd <= 1'b0;
      ib_wr <= 1'b0;
    end
  end

  // R9: request and payload held until acknowledge
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !ib_ack |=> busy && $stable(ib_addr) && $stable(ib_wdata) && $stable(ib_rd));
  // R9: at most one strobe
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ib_rd, ib_wr}));
  // R9: strobe released after acknowledge
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R12: strobe rises the cycle after launch
  p_start_r12: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);
endmodule

// File: rtl/regwin_status.sv
`timescale 1ns/1ps
module regwin_status #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          done,
  input  logic          done_is_rd,
  input  logic [DW-1:0] ib_rdata,
  output logic          valid,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      rdata <= '0;
    end else begin
      if (launch)    valid <= 1'b0;
      else if (done) valid <= 1'b1;
      if (done && done_is_rd) rdata <= ib_rdata;
    end
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    launch |=> !valid);
  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> valid);
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    valid && !launch |=> valid);
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    done && done_is_rd |=> rdata == $past(ib_rdata));
  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    done && !done_is_rd |=> $stable(rdata));
endmodule

// File: rtl/regwin_bridge.sv
`timescale 1ns/1ps
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_wr_en,
  input  logic                 host_rd_en,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic [HOST_DW-1:0]   host_wdata,
  output logic [HOST_DW-1:0]   host_rdata,
  output logic                 host_rvalid,
  input  logic                 cfg_lsb_first,
  input  logic [PW_WIDTH_W-1:0] cfg_word_bits,
  input  logic [PW_CS_W-1:0]   cfg_cs_count,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  input  logic [PW_ID_W-1:0]   cfg_periph_id,
  output logic                 ib_rd,
  output logic                 ib_wr,
  output logic [CW_ADDR_W-1:0] ib_addr,
  output logic [CW_DATA_W-1:0] ib_wdata,
  input  logic                 ib_ack,
  input  logic [CW_DATA_W-1:0] ib_rdata
);
  logic               ctrl_wr, launch, busy, done, done_is_rd, st_valid;
  logic [CW_DATA_W-1:0] st_rdata;
  logic [HOST_DW-1:0] param_word, status_word;
  req_t               req;

  always_comb begin
    param_word = '0;
    param_word[PW_ORDER_BIT]             = cfg_lsb_first;
    param_word[PW_WIDTH_LSB +: PW_WIDTH_W] = cfg_word_bits;
    param_word[PW_CS_LSB +: PW_CS_W]     = cfg_cs_count;
    param_word[PW_CPOL_BIT]              = cfg_cpol;
    param_word[PW_CPHA_BIT]              = cfg_cpha;
    param_word[PW_ID_LSB +: PW_ID_W]     = cfg_periph_id;
  end

  always_comb begin
    status_word = '0;
    status_word[SW_DATA_LSB +: CW_DATA_W] = st_rdata;
    status_word[SW_VALID_BIT]             = st_valid;
  end

  regwin_host_if #(.HOST_AW(HOST_AW)) u_host (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .param_word(param_word), .status_word(status_word),
    .ctrl_wr(ctrl_wr), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  regwin_cmd_decode u_dec (
    .ctrl_wr(ctrl_wr), .ctrl_word(host_wdata), .busy(busy),
    .launch(launch), .req(req)
  );

  regwin_seq u_seq (
    .clk(clk), .rst(rst), .launch(launch), .req(req), .ib_ack(ib_ack),
    .ib_rd(ib_rd), .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .busy(busy), .done(done), .done_is_rd(done_is_rd)
  );

  regwin_status #(.DW(CW_DATA_W)) u_stat (
    .clk(clk), .rst(rst), .launch(launch), .done(done),
    .done_is_rd(done_is_rd), .ib_rdata(ib_rdata),
    .valid(st_valid), .rdata(st_rdata)
  );

  // R8: a control write while busy never restarts the bus
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    busy && ctrl_wr && !ib_ack |=> $stable(ib_addr) && $stable(ib_wdata));
  // R11/R4: status upper bits stay clear
  p_status_hi_r4: assert property (@(posedge clk) disable iff (rst)
    host_rd_en && (host_addr[HOST_AW-1:WORD_BYTES_LG] == (HOST_AW-WORD_BYTES_LG)'(IX_STAT))
    |=> host_rdata[HOST_DW-1:SW_VALID_BIT+1] == '0);
endmodule

// File: tb/regwin_bridge_tb_top.sv
`timescale 1ns/1ps
module regwin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        host_rvalid;
  logic        cfg_lsb_first = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [5:0]  cfg_word_bits = '0, cfg_cs_count = '0;
  logic [15:0] cfg_periph_id = '0;
  logic        ib_rd, ib_wr, ib_ack;
  logic [12:0] ib_addr;
  logic [31:0] ib_wdata, ib_rdata;

  localparam logic [4:0] A_HOLE = 5'h00, A_PARAM = 5'h08, A_CTRL = 5'h10, A_STAT = 5'h18;

  int total = 0, bad = 0;
  int lat = 0, wcnt, txn_cnt;
  logic [12:0] last_addr;
  logic [31:0] smem [8];

  always #2.5 clk = ~clk;

  regwin_bridge dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .cfg_lsb_first(cfg_lsb_first),
    .cfg_word_bits(cfg_word_bits), .cfg_cs_count(cfg_cs_count),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_periph_id(cfg_periph_id),
    .ib_rd(ib_rd), .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  // model slave: acknowledges lat cycles after first seeing a strobe
  always @(posedge clk) begin
    if (rst) begin
      ib_ack <= 1'b0; ib_rdata <= '0; wcnt <= 0; txn_cnt <= 0; last_addr <= '0;
      for (int k = 0; k < 8; k++) smem[k] <= 32'hDEAD0000 + k;
    end else if ((ib_rd || ib_wr) && !ib_ack) begin
      if (wcnt >= lat) begin
        ib_ack <= 1'b1; wcnt <= 0; txn_cnt <= txn_cnt + 1; last_addr <= ib_addr;
        if (ib_rd) ib_rdata <= smem[ib_addr[4:2]];
        else smem[ib_addr[4:2]] <= ib_wdata;
      end else wcnt <= wcnt + 1;
    end else ib_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic host_write(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk); host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [4:0] a, output logic [63:0] d);
    @(negedge clk); host_rd_en = 1'b1; host_addr = a;
    @(negedge clk); host_rd_en = 1'b0; d = host_rdata;
  endtask

  task automatic poll(output int n, output logic [63:0] st);
    n = 0;
    do begin host_read(A_STAT, st); n++; end while (!st[32] && n < 40);
  endtask

  function automatic logic [63:0] mk(input logic [1:0] c, input logic [12:0] a, input logic [31:0] d);
    return {c, 17'b0, a, d};
  endfunction

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [63:0] rd, exp;
    logic [31:0] model_rd, wd, keep6;
    int n, t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk(!ib_rd && !ib_wr && !host_rvalid, "R11", {ib_rd, ib_wr, host_rvalid}, 0);
    host_read(A_STAT, rd);
    chk(rd == 0, "R11", rd, 0);
    chk(host_rvalid, "R1", host_rvalid, 1);

    // R10 parameter word sweep
    for (int p = 0; p < 6; p++) begin
      cfg_lsb_first = p[0]; cfg_cpol = p[1]; cfg_cpha = p[2];
      cfg_word_bits = 6'(p * 7 + 3); cfg_cs_count = 6'(p + 1);
      cfg_periph_id = 16'(p * 16'h1357 + 1);
      exp = (64'(cfg_periph_id) << 32) | (64'(cfg_cpha) << 15) | (64'(cfg_cpol) << 14) |
            (64'(cfg_cs_count) << 8) | (64'(cfg_word_bits) << 2) | (64'(cfg_lsb_first) << 1);
      host_read(A_PARAM, rd);
      chk(rd == exp, "R10", rd, exp);
    end
    host_read(A_HOLE, rd);
    chk(rd == 0, "R1", rd, 0);

    // R2 R3 R4 R6 R7 R12 sweep over latency and address
    model_rd = 32'h0;
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int i = 0; i < 8; i++) begin
        wd = 32'hC3000000 ^ (32'(l) << 12) ^ (32'(i) * 32'h00010101);
        t0 = txn_cnt;
        host_write(A_CTRL, mk(2'd2, 13'h1000 + 13'(i * 4), wd));
        poll(n, rd);
        chk(n == (l + 4) / 2, "R12", 64'(n), 64'((l + 4) / 2));
        chk(txn_cnt == t0 + 1, "R3", 64'(txn_cnt), 64'(t0 + 1));
        chk(last_addr == 13'h1000 + 13'(i * 4), "R2", 64'(last_addr), 64'(13'h1000 + 13'(i * 4)));
        chk(smem[i] == wd, "R2", 64'(smem[i]), 64'(wd));
        chk(rd[31:0] == model_rd, "R7", 64'(rd[31:0]), 64'(model_rd));
        chk(rd[63:33] == 0, "R4", rd, 64'(model_rd) | 64'h1_0000_0000);
        host_write(A_CTRL, mk(2'd1, 13'h1000 + 13'(i * 4), 32'hFFFFFFFF));
        poll(n, rd);
        chk(rd == ({31'b0, 1'b1, wd}), "R6", rd, {31'b0, 1'b1, wd});
        model_rd = wd;
      end
    end

    // R1 control read-back
    host_read(A_CTRL, rd);
    exp = mk(2'd1, 13'h101C, 32'hFFFFFFFF);
    chk(rd == exp, "R1", rd, exp);

    // R3 no-op and reserved command leave status and bus alone
    t0 = txn_cnt;
    host_write(A_CTRL, mk(2'd0, 13'h1004, 32'h12345678));
    host_write(A_CTRL, mk(2'd3, 13'h1008, 32'h12345678));
    repeat (6) @(negedge clk);
    host_read(A_STAT, rd);
    chk(rd == {31'b0, 1'b1, model_rd} && txn_cnt == t0, "R3", rd, {31'b0, 1'b1, model_rd});

    // R5 sticky across other-offset writes
    host_write(A_PARAM, '1);
    host_write(A_STAT, '0);
    host_read(A_STAT, rd);
    chk(rd == {31'b0, 1'b1, model_rd}, "R5", rd, {31'b0, 1'b1, model_rd});

    // R5 clear on launch, R8 ignore while busy
    lat = 3;
    keep6 = smem[6];
    t0 = txn_cnt;
    host_write(A_CTRL, mk(2'd2, 13'h1014, 32'h11111111));
    host_write(A_CTRL, mk(2'd2, 13'h1018, 32'h22222222));
    host_read(A_STAT, rd);
    chk(rd[32] == 1'b0, "R5", rd, {31'b0, 1'b0, model_rd});
    poll(n, rd);
    chk(rd[32] == 1'b1, "R5", rd, {31'b0, 1'b1, model_rd});
    chk(txn_cnt == t0 + 1, "R8", 64'(txn_cnt), 64'(t0 + 1));
    chk(smem[5] == 32'h11111111, "R8", 64'(smem[5]), 64'h11111111);
    chk(smem[6] == keep6, "R8", 64'(smem[6]), 64'(keep6));
    chk(last_addr == 13'h1014, "R8", 64'(last_addr), 64'h1014);

    // R9 strobe low after completion
    chk(!ib_rd && !ib_wr, "R9", {ib_rd, ib_wr}, 0);

    report();
    $finish;
  end
endmodule